// File: doc/BRIEF.md
# Processor Status Register with Exception Save

This block holds the live status word of a small processor core, together with a second word that stores a snapshot of it. The live word carries two things. The first is the condition flags produced by the ALU: negative, zero, carry, overflow and a sticky saturation bit. The second is the control state: the IRQ and FIQ masks, a compact-instruction-set state bit and a 5-bit mode field. Flag-setting instructions that retire with a passing condition update the flags. Instructions without the set-flags qualifier, and instructions whose condition fails, leave the flags alone.

When an interrupt request is taken, the live word is copied into the snapshot register in the same cycle. The live word then switches to IRQ mode with IRQ masked. An exception-return request copies the snapshot back, which restores the interrupted mode and flags. Software can write either register one byte field at a time and can read either one. The snapshot register can only be reached from a privileged mode. In user mode, software cannot change the control byte of the live word.

Top module: `psr_unit`

## Requirements
- R1: After reset the live word reads 32'h0000_00D3 (supervisor mode 5'b10011 in bits 4:0, IRQ mask bit 7 = 1, FIQ mask bit 6 = 1, state bit 5 = 0, flags clear), and the snapshot word reads zero.
- R2: Bits 26:8 of both words always read zero. A software write with field-enable bit 2 or bit 1 set (bytes 23:16 and 15:8) changes nothing.
- R3: A retiring instruction with cond_pass_i=1 and set_flags_i=1 loads alu_nzcv_i[3:0] into bits 31:28 in N, Z, C, V order, visible on the next cycle.
- R4: With set_flags_i=0, or with cond_pass_i=0, bits 31:28 keep their value. With cond_pass_i=0, bit 27 is not set either.
- R5: A retiring instruction with cond_pass_i=1 and sat_i=1 sets the sticky bit 27 whatever set_flags_i is. Only a software write to the flags byte can clear it.
- R6: irq_ack_o is high in the same cycle exactly when irq_req_i=1 and bit 7 of the live word is 0. On the next cycle the snapshot holds the old live word, the mode reads 5'b10010, bit 7 reads 1, and all other bits are unchanged.
- R7: exc_ret_i in a privileged mode (mode other than user 5'b10000) copies the snapshot into the live word. In user mode it has no effect.
- R8: In user mode a read of the snapshot (rd_saved_i=1) returns zero and a software write to it changes nothing. In privileged modes both work through the byte field enables.
- R9: wr_field_i bit 3 enables bits 31:27 and bit 0 enables bits 7:0. In user mode a write of the control byte of the live word is ignored, while its flags byte is still written.
- R10: When several requests arrive in one cycle, only the highest one takes effect. The order is: accepted IRQ, then exception return, then software write, then retire flag update.
- R11: rd_data_o shows, in the same cycle, the live word when rd_saved_i=0 and the snapshot (gated by R8) when rd_saved_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| retire_i | input | 1 | An instruction retires this cycle |
| cond_pass_i | input | 1 | The retiring instruction's condition evaluated true |
| set_flags_i | input | 1 | The retiring instruction is the flag-setting variant |
| alu_nzcv_i | input | 4 | ALU flags N, Z, C, V (bit 3 down to bit 0) |
| sat_i | input | 1 | The retiring instruction saturated |
| irq_req_i | input | 1 | Interrupt request |
| irq_ack_o | output | 1 | Interrupt accepted this cycle |
| exc_ret_i | input | 1 | Exception return request |
| wr_en_i | input | 1 | Software write strobe |
| wr_saved_i | input | 1 | The write targets the snapshot (1) or the live word (0) |
| wr_field_i | input | 4 | Byte field enables, bit n covers bits 8n+7:8n |
| wr_data_i | input | 32 | Software write data |
| rd_saved_i | input | 1 | The read selects the snapshot (1) or the live word (0) |
| rd_data_o | output | 32 | Read data |
| cur_o | output | 32 | Live status word |

## Verification
A fault in the live word shows on cur_o on the edge that introduced it. This holds whether the fault is a flag taken from an instruction that should not set flags, a lost sticky bit, or a mode byte that user code managed to change. A fault in the snapshot stays hidden until it is read in a privileged mode, or until an exception return copies it into cur_o one cycle after the request. The bench therefore reads the snapshot back after every interrupt entry and exercises returns from many different saved states. It also checks the mirror case, where a snapshot must not leak to user mode through rd_data_o.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int WORD_W  = 32;
  localparam int FIELD_W = 8;
  localparam int NFIELD  = WORD_W / FIELD_W;
  localparam int MODE_W  = 5;

  localparam int BIT_N = 31;
  localparam int BIT_Z = 30;
  localparam int BIT_C = 29;
  localparam int BIT_V = 28;
  localparam int BIT_Q = 27;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_USR = 5'b10000;
  localparam mode_t MODE_IRQ = 5'b10010;
  localparam mode_t MODE_SVC = 5'b10011;

  // implemented bits: flags 31:27, control 7:0
  localparam logic [WORD_W-1:0] IMPL_MASK = 32'hF800_00FF;
  localparam logic [WORD_W-1:0] RESET_WORD =
    (WORD_W'(1) << BIT_I) | (WORD_W'(1) << BIT_F) | WORD_W'(MODE_SVC);
endpackage

// File: rtl/psr_field_merge.sv
module psr_field_merge
  import psr_pkg::*;
#(
  parameter int                W     = WORD_W,
  parameter int                FW    = FIELD_W,
  parameter logic [W-1:0]      IMPL  = IMPL_MASK
) (
  input  logic [W-1:0]    old_i,
  input  logic [W-1:0]    wdata_i,
  input  logic [W/FW-1:0] en_i,
  output logic [W-1:0]    new_o
);
  localparam int NF = W / FW;

  for (genvar f = 0; f < NF; f++) begin : g_field
    logic [FW-1:0] keep;
    assign keep = IMPL[f*FW +: FW];
    assign new_o[f*FW +: FW] = en_i[f]
      ? ((wdata_i[f*FW +: FW] & keep) | (old_i[f*FW +: FW] & ~keep))
      : old_i[f*FW +: FW];
  end
endmodule

// File: rtl/psr_flag_unit.sv
module psr_flag_unit (
  input  logic       retire_i,
  input  logic       cond_pass_i,
  input  logic       set_flags_i,
  input  logic [3:0] nzcv_i,
  input  logic       sat_i,
  input  logic [4:0] flags_i,  // N Z C V Q
  output logic [4:0] flags_o
);
  logic go;
  assign go = retire_i & cond_pass_i;

  always_comb begin
    flags_o = flags_i;
    if (go && set_flags_i) flags_o[4:1] = nzcv_i;
    if (go && sat_i)       flags_o[0]   = 1'b1;
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        retire_i,
  input  logic        cond_pass_i,
  input  logic        set_flags_i,
  input  logic [3:0]  alu_nzcv_i,
  input  logic        sat_i,
  input  logic        irq_req_i,
  output logic        irq_ack_o,
  input  logic        exc_ret_i,
  input  logic        wr_en_i,
  input  logic        wr_saved_i,
  input  logic [3:0]  wr_field_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_saved_i,
  output logic [31:0] rd_data_o,
  output logic [31:0] cur_o
);
  logic [WORD_W-1:0] cur_q, cur_d, sav_q, sav_d;
  logic [WORD_W-1:0] cur_wr, sav_wr;
  logic [NFIELD-1:0] cur_en;
  logic [4:0]        flag_nx;
  logic              priv;

  assign priv      = cur_q[MODE_W-1:0] != MODE_USR;
  assign irq_ack_o = irq_req_i & ~cur_q[BIT_I];
  assign cur_en    = wr_field_i & {{(NFIELD-1){1'b1}}, priv};

  psr_field_merge u_cur_merge (
    .old_i(cur_q), .wdata_i(wr_data_i), .en_i(cur_en), .new_o(cur_wr)
  );
  psr_field_merge u_sav_merge (
    .old_i(sav_q), .wdata_i(wr_data_i), .en_i(wr_field_i), .new_o(sav_wr)
  );
  psr_flag_unit u_flags (
    .retire_i(retire_i), .cond_pass_i(cond_pass_i), .set_flags_i(set_flags_i),
    .nzcv_i(alu_nzcv_i), .sat_i(sat_i), .flags_i(cur_q[BIT_N:BIT_Q]),
    .flags_o(flag_nx)
  );

  always_comb begin
    cur_d = cur_q;
    sav_d = sav_q;
    if (irq_ack_o) begin
      sav_d                = cur_q;
      cur_d[MODE_W-1:0]    = MODE_IRQ;
      cur_d[BIT_I]         = 1'b1;
    end else if (exc_ret_i) begin
      if (priv) cur_d = sav_q;
    end else if (wr_en_i) begin
      if (wr_saved_i) begin
        if (priv) sav_d = sav_wr;
      end else begin
        cur_d = cur_wr;
      end
    end else begin
      cur_d[BIT_N:BIT_Q] = flag_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= RESET_WORD;
      sav_q <= '0;
    end else begin
      cur_q <= cur_d;
      sav_q <= sav_d;
    end
  end

  assign cur_o     = cur_q;
  assign rd_data_o = rd_saved_i ? (priv ? sav_q : '0) : cur_q;

  // assertions
  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur_o & ~IMPL_MASK) == '0) && ((sav_q & ~IMPL_MASK) == '0));

  p_irq_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (sav_q == $past(cur_o)) && (cur_o[4:0] == MODE_IRQ) && cur_o[BIT_I]
                  && (cur_o[31:8] == $past(cur_o[31:8])));

  p_eret_restore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_ret_i && !irq_ack_o && cur_o[4:0] != MODE_USR) |=> cur_o == $past(sav_q));

  p_cond_fail_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_ack_o && !exc_ret_i && !wr_en_i && !(retire_i && cond_pass_i)) |=> $stable(cur_o));

  p_user_saved_hidden_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_saved_i && cur_o[4:0] == MODE_USR) |-> rd_data_o == '0);

  p_user_ctrl_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o[4:0] == MODE_USR && !irq_ack_o) |=> cur_o[7:0] == $past(cur_o[7:0]));

  p_ack_needs_unmask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> !cur_o[BIT_I]);
endmodule

// File: tb/psr_unit_test.sv
`timescale 1ns/1ps
module psr_unit_test;
  logic        clk = 0, rst_n = 0;
  logic        retire = 0, cond = 0, sf = 0, sat = 0;
  logic [3:0]  nzcv = 0;
  logic        irq = 0, eret = 0, we = 0, wsav = 0, rsav = 0;
  logic [3:0]  wfield = 0;
  logic [31:0] wdata = 0;
  logic        ack;
  logic [31:0] rdata, cur;

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference state
  logic [31:0] m_cur, m_sav;

  always #4 clk = ~clk;

  psr_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .retire_i(retire), .cond_pass_i(cond),
    .set_flags_i(sf), .alu_nzcv_i(nzcv), .sat_i(sat), .irq_req_i(irq),
    .irq_ack_o(ack), .exc_ret_i(eret), .wr_en_i(we), .wr_saved_i(wsav),
    .wr_field_i(wfield), .wr_data_i(wdata), .rd_saved_i(rsav),
    .rd_data_o(rdata), .cur_o(cur)
  );

  function automatic bit m_priv();
    return m_cur[4:0] != 5'h10;
  endfunction

  function automatic logic [31:0] put_bytes(logic [31:0] old, logic [31:0] d,
                                            logic flg, logic ctl);
    logic [31:0] r;
    r = old;
    if (flg) r[31:27] = d[31:27];
    if (ctl) r[7:0]   = d[7:0];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = 32'h0000_00D3;
      m_sav = 32'h0;
    end else if (irq && !m_cur[7]) begin
      m_sav = m_cur;
      m_cur[4:0] = 5'h12;
      m_cur[7] = 1'b1;
    end else if (eret) begin
      if (m_priv()) m_cur = m_sav;
    end else if (we) begin
      if (wsav) begin
        if (m_priv()) m_sav = put_bytes(m_sav, wdata, wfield[3], wfield[0]);
      end else begin
        m_cur = put_bytes(m_cur, wdata, wfield[3], wfield[0] && m_priv());
      end
    end else if (retire && cond) begin
      if (sf)  m_cur[31:28] = nzcv;
      if (sat) m_cur[27] = 1'b1;
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [31:0] exp_rd;
    exp_rd = rsav ? (m_priv() ? m_sav : 32'h0) : m_cur;
    chk(tag, cur, m_cur);
    chk(tag, rdata, exp_rd);
    chk(tag, {31'h0, ack}, {31'h0, irq && !m_cur[7]});
  endtask

  task automatic cyc(string t, logic i_irq, logic i_eret, logic i_we, logic i_wsav,
                     logic [3:0] i_wf, logic [31:0] i_wd, logic i_ret, logic i_cond,
                     logic i_sf, logic [3:0] i_nzcv, logic i_sat, logic i_rsav);
    @(negedge clk);
    compare_all();
    tag = t;
    irq = i_irq; eret = i_eret; we = i_we; wsav = i_wsav; wfield = i_wf;
    wdata = i_wd; retire = i_ret; cond = i_cond; sf = i_sf; nzcv = i_nzcv;
    sat = i_sat; rsav = i_rsav;
  endtask

  task automatic idle(string t);
    cyc(t, 0,0,0,0,4'h0,32'h0,0,0,0,4'h0,0,0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", cur, 32'h0000_00D3);
    rsav = 1; #1;
    chk("R1", rdata, 32'h0);
    rsav = 0;
    @(negedge clk);
    rst_n = 1;

    // R9 privileged control write -> user mode, I=F=0
    cyc("R9", 0,0,1,0,4'b0001,32'h0000_0010,0,0,0,4'h0,0,0);
    idle("R9");
    chk("R9", cur, 32'h0000_0010);
    // R9 user cannot touch control byte
    cyc("R9", 0,0,1,0,4'b0001,32'h0000_00D3,0,0,0,4'h0,0,0);
    idle("R9");
    chk("R9", cur, 32'h0000_0010);
    // R8 user write to snapshot ignored, read returns zero
    cyc("R8", 0,0,1,1,4'b1001,32'hFFFF_FFFF,0,0,0,4'h0,0,0);
    cyc("R8", 0,0,0,0,4'h0,32'h0,0,0,0,4'h0,0,1);
    #1 chk("R8", rdata, 32'h0);
    // R2 reserved fields
    cyc("R2", 0,0,1,0,4'b0110,32'hFFFF_FFFF,0,0,0,4'h0,0,0);
    idle("R2");
    chk("R2", cur, 32'h0000_0010);
    // R3 flag-setting retire
    cyc("R3", 0,0,0,0,4'h0,32'h0,1,1,1,4'b1010,0,0);
    idle("R3");
    chk("R3", cur, 32'hA000_0010);
    // R4 condition fails
    cyc("R4", 0,0,0,0,4'h0,32'h0,1,0,1,4'b0101,1,0);
    idle("R4");
    chk("R4", cur, 32'hA000_0010);
    // R5 saturation without set-flags
    cyc("R5", 0,0,0,0,4'h0,32'h0,1,1,0,4'b0101,1,0);
    idle("R5");
    chk("R5", cur, 32'hA800_0010);
    cyc("R5", 0,0,0,0,4'h0,32'h0,1,1,1,4'b0000,0,0);
    idle("R5");
    chk("R5", cur, 32'h0800_0010);
    // R6 IRQ entry
    cyc("R6", 1,0,0,0,4'h0,32'h0,0,0,0,4'h0,0,0);
    #1 chk("R6", {31'h0, ack}, 32'h1);
    cyc("R6", 0,0,0,0,4'h0,32'h0,0,0,0,4'h0,0,1);
    #1 chk("R6", cur, 32'h0800_0092);
    chk("R11", rdata, 32'h0800_0010);
    cyc("R6", 1,0,0,0,4'h0,32'h0,0,0,0,4'h0,0,0);
    #1 chk("R6", {31'h0, ack}, 32'h0);
    // R10 eret beats write and retire
    cyc("R10", 0,1,1,0,4'b1001,32'hFFFF_FFFF,1,1,1,4'b1111,0,0);
    idle("R10");
    chk("R10", cur, 32'h0800_0010);
    // R10 IRQ beats retire
    cyc("R10", 1,0,0,0,4'h0,32'h0,1,1,1,4'b1111,0,0);
    idle("R10");
    chk("R10", cur, 32'h0800_0092);
    // R7 return, then return in user ignored
    cyc("R7", 0,1,0,0,4'h0,32'h0,0,0,0,4'h0,0,0);
    idle("R7");
    chk("R7", cur, 32'h0800_0010);
    cyc("R7", 0,0,0,0,4'h0,32'h0,1,1,1,4'b1100,0,0);
    cyc("R7", 0,1,0,0,4'h0,32'h0,0,0,0,4'h0,0,0);
    idle("R7");
    chk("R7", cur, 32'hC800_0010);
    // R11 live read
    cyc("R11", 0,0,0,0,4'h0,32'h0,0,0,0,4'h0,0,0);
    #1 chk("R11", rdata, cur);
    // R9 user flags byte write clears Q
    cyc("R9", 0,0,1,0,4'b1000,32'h3000_0000,0,0,0,4'h0,0,0);
    idle("R9");
    chk("R9", cur, 32'h3000_0010);

    // randomised traffic against the reference model
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] d;
      logic [2:0] msel;
      d = $urandom;
      msel = 3'($urandom % 3);
      d[4:0] = (msel == 0) ? 5'h10 : (msel == 1) ? 5'h12 : 5'h13;
      cyc("R10",
          ($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
          1'($urandom), 4'($urandom), d,
          1'($urandom), ($urandom % 4) != 0, 1'($urandom), 4'($urandom),
          ($urandom % 5) == 0, 1'($urandom));
    end
    idle("R10");
    idle("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule